// File: doc/BRIEF.md
# Three-Channel Prescaled Timer Counter

This block holds three independent up-counters that share one input clock. Each channel has its own divider, control word, compare registers, sticky event flags and a level interrupt line. Software programs and observes all three through a single synchronous register port. A read request presented at one clock edge returns its data on `reg_rdata` from that edge on.

A channel either runs free, wrapping at the top of its range, or runs in interval mode. In interval mode it restarts at zero once it reaches a programmed limit, and it flags an event each time it does so. Three compare registers per channel flag further events when the count passes through their values. A self-clearing reset control restarts a channel from zero, so a newly programmed interval is timed from a known point. Events latch into a status word that clears on read. A per-bit enable word decides which events drive the channel's interrupt.

The register map interleaves the three channels. Each register kind occupies one 12-byte row, and the channels sit at 4-byte steps inside that row. Drivers written for this layout can therefore reach a given register of channel c by adding 4*c to the channel-0 offset.

Top module: `ptc_timer3`

## Requirements
- R1: After reset every channel's counter control reads 0x21 (disabled, waveform bit set). Every other register reads 0, and `irq` is all zero.
- R2: The register of kind k for channel c sits at byte offset 12*k + 4*c. Address bits [1:0] are ignored. The kinds are: k=0 clock control, 1 counter control, 2 count value, 3 interval, 4/5/6 compare 1/2/3, 7 status, 8 interrupt enable. The count value is read-only, and writes to it are ignored.
- R3: With clock control bit 0 clear, an enabled free-running channel adds one on every clock. Its count wraps from 0xFFFF to 0x0000.
- R4: Clock control bit 0 enables division and bits [4:1] hold N. With division on, the count advances once every 2^(N+1) clocks, so the value 0x9 gives one step per 32 clocks. Clock control reads back as written in bits [4:0].
- R5: While counter control bit 0 (disable) is set, the count holds and no events are flagged.
- R6: Writing counter control with bit 4 set forces the count and the divider to zero at that edge. Bit 4 always reads back as 0.
- R7: When counter control bit 1 is set, a step taken while the count equals the interval register returns the count to 0 and sets status bit 0.
- R8: A step taken while the count equals compare register j (j = 1..3) sets status bit j.
- R9: `irq[c]` is high exactly while some status bit of channel c is set together with the same bit of that channel's enable register.
- R10: A status read returns the latched bits and clears them at the same edge. An event arriving at that edge stays set.
- R11: Writes to the status register change nothing.
- R12: Counter control bit 5 is stored and read back and has no other effect. Counter control reads back bits 0, 1 and 5 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared by all channels |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, registered at the read edge |
| irq | output | NUM_CH (3) | Level interrupt, one per channel |

## Verification
The bench builds the block with its default parameters: three channels, 16-bit counts and the divider variant included. Because the count is 16 bits wide, a full wrap of one channel from 0xFFFF to zero takes about 65 thousand clocks and fits in the run. The 4-bit divide field makes a divide-by-32 setting reachable, so exact step edges can be checked after a counter reset. The three channels let the bench show the interleaved map and show that one channel's interrupt stays independent of the others.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int N_MATCH  = 3;
   localparam int STS_W    = N_MATCH + 1;
   localparam int NUM_KIND = 9;
   localparam int KIND_W   = 4;

   // register kinds, one 12-byte row each
   localparam logic [KIND_W-1:0] K_CLK = 4'd0;
   localparam logic [KIND_W-1:0] K_CTL = 4'd1;
   localparam logic [KIND_W-1:0] K_VAL = 4'd2;
   localparam logic [KIND_W-1:0] K_IVL = 4'd3;
   localparam logic [KIND_W-1:0] K_MT1 = 4'd4;
   localparam logic [KIND_W-1:0] K_STS = 4'd7;
   localparam logic [KIND_W-1:0] K_IEN = 4'd8;

   // counter control bit positions
   localparam int CTL_DIS_B = 0;
   localparam int CTL_IVL_B = 1;
   localparam int CTL_CLR_B = 4;
   localparam int CTL_WAV_B = 5;
   // clock control bit positions
   localparam int CLK_PEN_B = 0;
   localparam int CLK_N_LSB = 1;

   typedef struct packed {
      logic wav;
      logic ivl;
      logic dis;
   } ctl_t;

   localparam ctl_t CTL_RST = '{wav: 1'b1, ivl: 1'b0, dis: 1'b1};
endpackage

// File: rtl/ptc_addr_decode.sv
module ptc_addr_decode
   import ptc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_CH = 3,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [KIND_W-1:0] kind,
   output logic [CH_W-1:0]   ch
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   int                row;
   int                col;

   assign word = addr[ADDR_W-1:2];

   always_comb begin
      row  = int'(word) / NUM_CH;
      col  = int'(word) % NUM_CH;
      hit  = (row < NUM_KIND);
      kind = KIND_W'(row);
      ch   = CH_W'(col);
   end
endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
   parameter int PSC_W   = 4,
   parameter bit HAS_PSC = 1'b1,
   localparam int DIV_W  = 1 << PSC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             pen,
   input  logic [PSC_W-1:0] n_sel,
   output logic             tick
);
   generate
      if (HAS_PSC) begin : g_div
         logic [DIV_W-1:0] pcnt_q;
         logic [DIV_W:0]   lim_w;
         logic             last;

         // ratio 2^(N+1): the last divider value is (N+1) ones
         assign lim_w = ({{DIV_W{1'b0}}, 1'b1} << ({1'b0, n_sel} + 1'b1)) - 1'b1;
         assign last  = (pcnt_q == lim_w[DIV_W-1:0]);
         assign tick  = run && (!pen || last);

         always_ff @(posedge clk) begin
            if (!rst_n || restart)
               pcnt_q <= '0;
            else if (run && pen)
               pcnt_q <= last ? '0 : pcnt_q + 1'b1;
         end
      end else begin : g_nodiv
         logic unused_sel;
         assign unused_sel = pen ^ (^n_sel) ^ restart ^ rst_n ^ clk;
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/ptc_channel.sv
module ptc_channel
   import ptc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 32,
   parameter int PSC_W   = 4,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [KIND_W-1:0] kind,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);
   logic              pen_q;
   logic [PSC_W-1:0]  nsel_q;
   ctl_t              ctl_q;
   logic [CNT_W-1:0]  ivl_q;
   logic [CNT_W-1:0]  mt_q [N_MATCH];
   logic [CNT_W-1:0]  count_q;
   logic [STS_W-1:0]  sts_q;
   logic [STS_W-1:0]  ien_q;
   logic [STS_W-1:0]  ev;
   logic              tick;
   logic              clr_req;
   logic              wrap_ivl;

   assign clr_req  = wr_en && (kind == K_CTL) && wdata[CTL_CLR_B];
   assign wrap_ivl = ctl_q.ivl && (count_q == ivl_q);

   ptc_prescaler #(.PSC_W(PSC_W), .HAS_PSC(HAS_PSC)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!ctl_q.dis),
      .restart (clr_req),
      .pen     (pen_q),
      .n_sel   (nsel_q),
      .tick    (tick)
   );

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pen_q  <= 1'b0;
         nsel_q <= '0;
         ctl_q  <= CTL_RST;
         ivl_q  <= '0;
         ien_q  <= '0;
      end else if (wr_en) begin
         case (kind)
            K_CLK: begin
               pen_q  <= wdata[CLK_PEN_B];
               nsel_q <= wdata[CLK_N_LSB +: PSC_W];
            end
            K_CTL: ctl_q <= '{wav: wdata[CTL_WAV_B], ivl: wdata[CTL_IVL_B],
                              dis: wdata[CTL_DIS_B]};
            K_IVL: ivl_q <= wdata;
            K_IEN: ien_q <= wdata[STS_W-1:0];
            default: ;
         endcase
      end
   end

   // compare registers and compare events
   assign ev[0] = tick && !clr_req && wrap_ivl;
   generate
      for (genvar k = 0; k < N_MATCH; k++) begin : g_mt
         always_ff @(posedge clk) begin
            if (!rst_n)
               mt_q[k] <= '0;
            else if (wr_en && (kind == KIND_W'(int'(K_MT1) + k)))
               mt_q[k] <= wdata;
         end
         assign ev[k+1] = tick && !clr_req && (count_q == mt_q[k]);
      end
   endgenerate

   // counter
   always_ff @(posedge clk) begin
      if (!rst_n || clr_req)
         count_q <= '0;
      else if (tick)
         count_q <= wrap_ivl ? '0 : count_q + 1'b1;
   end

   // sticky status: read clears, a same-edge event wins
   always_ff @(posedge clk) begin
      if (!rst_n)
         sts_q <= '0;
      else
         sts_q <= (rd_clr ? '0 : sts_q) | ev;
   end

   assign irq_o = |(sts_q & ien_q);

   always_comb begin
      rd_data = '0;
      case (kind)
         K_CLK: begin
            rd_data[CLK_PEN_B]            = pen_q;
            rd_data[CLK_N_LSB +: PSC_W]   = nsel_q;
         end
         K_CTL: begin
            rd_data[CTL_DIS_B] = ctl_q.dis;
            rd_data[CTL_IVL_B] = ctl_q.ivl;
            rd_data[CTL_WAV_B] = ctl_q.wav;
         end
         K_VAL:   rd_data[CNT_W-1:0] = count_q;
         K_IVL:   rd_data[CNT_W-1:0] = ivl_q;
         K_STS:   rd_data[STS_W-1:0] = sts_q;
         K_IEN:   rd_data[STS_W-1:0] = ien_q;
         default: begin
            for (int k = 0; k < N_MATCH; k++)
               if (kind == KIND_W'(int'(K_MT1) + k))
                  rd_data[CNT_W-1:0] = mt_q[k];
         end
      endcase
   end

   // ---------------- assertions ----------------
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.dis && !clr_req) |=> ($stable(count_q) && ((sts_q & ~$past(sts_q)) == '0))); // R5
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctl_q.ivl && !clr_req) |=> (count_q == CNT_W'($past(count_q) + 1'b1))); // R3
   AST_INTERVAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr_req && ctl_q.ivl && (count_q == ivl_q)) |=> ((count_q == '0) && sts_q[0])); // R7
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (count_q == '0)); // R6
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq_o); // R9
   AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && (sts_q != '0)) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R10
endmodule

// File: rtl/ptc_timer3.sv
module ptc_timer3
   import ptc_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int PSC_W   = 4,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   initial begin
      if (NUM_CH < 1 || NUM_KIND * NUM_CH * 4 > (1 << ADDR_W))
         $error("ptc_timer3: register map does not fit ADDR_W");
      if (CNT_W < 6 || CNT_W > DATA_W)
         $error("ptc_timer3: CNT_W must lie in 6..DATA_W");
      if (CLK_N_LSB + PSC_W > CNT_W)
         $error("ptc_timer3: divide field wider than the write path");
   end

   logic              hit;
   logic [KIND_W-1:0] kind;
   logic [CH_W-1:0]   ch;
   logic [DATA_W-1:0] chan_rd [NUM_CH];

   ptc_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr (reg_addr),
      .hit  (hit),
      .kind (kind),
      .ch   (ch)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic sel;
         assign sel = hit && (ch == CH_W'(c));
         ptc_channel #(
            .CNT_W(CNT_W), .DATA_W(DATA_W), .PSC_W(PSC_W), .HAS_PSC(HAS_PSC)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && sel),
            .kind    (kind),
            .wdata   (reg_wdata[CNT_W-1:0]),
            .rd_clr  (reg_rd && sel && (kind == K_STS)),
            .rd_data (chan_rd[c]),
            .irq_o   (irq[c])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= hit ? chan_rd[ch] : '0;
   end

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata)); // R2
endmodule

// File: tb/sim_ptc_timer3.sv
module sim_ptc_timer3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  irq;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [31:0] exp_q [$];
   logic [31:0] msk_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   ptc_timer3 u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   // offsets per R2: 12*kind + 4*channel
   function automatic logic [7:0] ra(input int kind, input int ch);
      return 8'(12 * kind + 4 * ch);
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int kind, input int ch, input logic [31:0] d);
      reg_addr = ra(kind, ch); reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: push expected item, issue read
   task automatic rd(input int kind, input int ch, input logic [31:0] e,
                     input logic [31:0] m, input string tag);
      exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(tag);
      reg_addr = ra(kind, ch); reg_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk_irq(input logic [2:0] e, input string tag);
      tests++;
      if (irq !== e) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
      end
   endtask

   // monitor: pop and compare once read data is returned
   always @(posedge clk) rd_seen <= reg_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [31:0] e, m;
         string t;
         e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
         tests++;
         if ((reg_rdata & m) !== (e & m)) begin
            fails++;
            $display("FAIL %s rdata actual=0x%08h expected=0x%08h", t, reg_rdata, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_irq(3'b000, "R1 irq after reset");
      rd(1, 0, 32'h21, ALL, "R1 ctl ch0");
      rd(1, 2, 32'h21, ALL, "R1 ctl ch2");
      rd(0, 1, 32'h0, ALL, "R1 clk ch1");
      rd(3, 0, 32'h0, ALL, "R1 interval ch0");
      rd(7, 1, 32'h0, ALL, "R1 status ch1");
      rd(8, 2, 32'h0, ALL, "R1 enable ch2");
      rd(2, 0, 32'h0, ALL, "R1 count ch0");

      // R3 free-run wrap on ch1, no division
      wr(1, 1, 32'h10);
      idle(65535);
      rd(2, 1, 32'hFFFF, ALL, "R3 count top ch1");
      rd(2, 1, 32'h0000, ALL, "R3 count wrap ch1");
      chk_irq(3'b000, "R9 ch1 runs with enable 0");
      wr(1, 1, 32'h23);
      rd(1, 1, 32'h23, ALL, "R12 ctl readback 0x23 ch1");

      // R5/R6 enable, self-clearing reset, disable hold on ch0
      wr(1, 0, 32'h10);
      rd(1, 0, 32'h00, ALL, "R6 reset bit reads 0");
      idle(4);
      wr(1, 0, 32'h01);
      idle(10);
      rd(2, 0, 32'd6, ALL, "R5 count held when disabled");
      rd(2, 0, 32'd6, ALL, "R5 count still held");
      wr(1, 0, 32'h11);
      rd(1, 0, 32'h01, ALL, "R6 ctl after reset write");
      rd(2, 0, 32'd0, ALL, "R6 count cleared");

      // R4 divide by 32 on ch0
      wr(0, 0, 32'h9);
      rd(0, 0, 32'h9, ALL, "R4 clk ctrl readback");
      wr(1, 0, 32'h10);
      idle(31);
      rd(2, 0, 32'd0, ALL, "R4 before first step");
      rd(2, 0, 32'd1, ALL, "R4 first step at 32");
      idle(62);
      rd(2, 0, 32'd2, ALL, "R4 second step");
      rd(2, 0, 32'd3, ALL, "R4 third step at 96");
      wr(1, 0, 32'h01);

      // R7/R8/R9/R10 interval mode on ch2
      wr(3, 2, 32'd4);
      wr(4, 2, 32'd2);
      wr(5, 2, 32'd100);
      wr(6, 2, 32'd100);
      wr(8, 2, 32'h1);
      wr(1, 2, 32'h12);
      idle(4);
      chk_irq(3'b000, "R7 no interval event yet");
      idle(1);
      chk_irq(3'b100, "R7 interval event raises irq ch2");
      rd(7, 2, 32'h3, ALL, "R8 status interval+match1");
      chk_irq(3'b000, "R10 irq low after status read");
      rd(7, 2, 32'h0, ALL, "R10 status cleared");
      rd(7, 2, 32'h0, ALL, "R10 read at match edge");
      chk_irq(3'b000, "R9 match1 set but not enabled");
      rd(7, 2, 32'h2, ALL, "R10 same-edge event wins");

      // R11 status writes ignored, R2 count read-only
      wr(8, 2, 32'h0);
      wr(1, 2, 32'h03);
      rd(7, 2, 32'h0, 32'h0, "R10 drain status");
      rd(7, 2, 32'h0, ALL, "R5 no events while disabled");
      wr(7, 2, 32'hF);
      wr(8, 2, 32'hF);
      chk_irq(3'b000, "R11 status write sets nothing");
      rd(7, 2, 32'h0, ALL, "R11 status unchanged");
      wr(1, 2, 32'h13);
      wr(2, 2, 32'hABCD);
      rd(2, 2, 32'h0, ALL, "R2 count value read-only");
      rd(1, 2, 32'h03, ALL, "R12 ctl bits 0,1 readback");

      idle(3);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule